// File: doc/BRIEF.md
# Enable-Gated Fibonacci Sequence Generator

This block emits the Fibonacci series, one new term on every rising clock edge at which the enable input is high. A synchronous active-low reset returns the series to its first term, zero. While enable is low, the output keeps the value it last showed, and the series picks up again from that value once enable returns.

Inside, a two-bit controller steps through four states: restart, first term, generating and holding. A small datapath keeps three 16-bit terms: the current one and the two before it. The next term is the sum of the current term and the one before it. The output is 17 bits wide and is the current 16-bit term with a zero on top. The internal terms wrap modulo 2^16, so F(25) and later terms come out reduced.

Top module: `fibgen_top`

## Requirements
- R1: Reset is active low and synchronous. At any rising edge where `rst_n` is 0, the output becomes 0 at that edge. Driving `rst_n` low between edges does not change the output before the next rising edge.
- R2: Reset wins over enable. With `rst_n` at 0 and `en` at 1 at an edge, the output is 0 after that edge.
- R3: At the first edge after reset where `en` is 1, the output goes to 1. Further enabled edges then give 1, 2, 3, 5, 8 in turn, so F(0)=0, F(1)=1 and F(n)=F(n-1)+F(n-2).
- R4: Each rising edge with `rst_n` at 1 and `en` at 1 moves the output forward by exactly one term.
- R5: Each rising edge with `rst_n` at 1 and `en` at 0 leaves the output unchanged, however many such edges come in a row.
- R6: After any number of held edges, the next enabled edge shows the term that follows the held one. No term is repeated and none is skipped.
- R7: Bit 16 of the output is always 0. Bits 15:0 carry the current term.
- R8: Terms are computed modulo 2^16. After F(24)=46368, the output shows F(25) mod 65536 = 9489, and the series continues from the wrapped values.
- R9: If `en` stays low after reset, the output stays at 0. The first enabled edge after that still gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low restart |
| en | input | 1 | High: advance one term per edge; low: hold |
| fib_out | output | 17 | Current term, zero-extended from 16 bits |

## Verification
Every output effect is due at the single rising edge where its inputs are sampled: a restart, an advance and a hold all appear one register stage after `rst_n` or `en` is applied. The bench changes its inputs just after a falling edge. It steps a 16-bit arithmetic model at the following rising edge and compares the output 1 ns after that edge, so each check looks at the result of exactly one edge. The asynchronous-reset check instead samples the output before the edge, while `rst_n` is already low. Every 8-edge enable pattern is swept from a fresh reset. A long enabled run crosses the 2^16 wrap.

// File: rtl/fib_pkg.sv
// Shared definitions for the Fibonacci generator.
// Assumes: the state encoding fits in two bits; the output stage decodes it.
package fib_pkg;

    // Controller states; the output stage decodes the restart and first-term codes
    typedef enum logic [1:0] {
        ST_RESTART = 2'b00,
        ST_FIRST   = 2'b01,
        ST_GEN     = 2'b10,
        ST_HOLD    = 2'b11
    } fib_state_e;

endpackage

// File: rtl/fib_seq_ctrl.sv
// Sequence controller: a four-state machine that tracks where the generator
// stands in the series and tells the datapath when to reload or advance.
// Assumes: rst_n is synchronous and active low, and it takes priority over en.
module fib_seq_ctrl
    import fib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output fib_state_e state_q,
    output logic       load_init,
    output logic       advance
);

    fib_state_e state_d;

    // Next-state selection: restart dominates, then the enable decides
    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d = ST_RESTART;
        end else if (!en) begin
            state_d = (state_q == ST_RESTART) ? ST_RESTART : ST_HOLD;
        end else begin
            unique case (state_q)
                ST_RESTART: state_d = ST_FIRST;
                ST_FIRST:   state_d = ST_GEN;
                ST_GEN:     state_d = ST_GEN;
                ST_HOLD:    state_d = ST_GEN;
                default:    state_d = ST_RESTART;
            endcase
        end
    end

    // Datapath commands, taken straight from the sampled inputs
    always_comb begin
        load_init = !rst_n;
        advance   = rst_n && en;
    end

    // State register with synchronous restart
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

endmodule

// File: rtl/fib_term_path.sv
// Term datapath: three registers hold the current term and the two before it.
// Advancing shifts the terms down and loads the sum of the current and the
// previous term.
// Assumes: arithmetic wraps at TERM_W bits. After a restart the terms are
// F(0)=0, F(-1)=1 and F(-2)=-1 (all ones), so the first advance gives 1 with
// no special case.
module fib_term_path #(
    parameter int TERM_W = 16
) (
    input  logic              clk,
    input  logic              load_init,
    input  logic              advance,
    output logic [TERM_W-1:0] cur_q,
    output logic [TERM_W-1:0] m1_q,
    output logic [TERM_W-1:0] m2_q
);

    localparam logic [TERM_W-1:0] INIT_CUR = '0;
    localparam logic [TERM_W-1:0] INIT_M1  = TERM_W'(1);
    localparam logic [TERM_W-1:0] INIT_M2  = '1;

    logic [TERM_W-1:0] sum_d;
    logic [TERM_W-1:0] cur_d;
    logic [TERM_W-1:0] m1_d;
    logic [TERM_W-1:0] m2_d;

    // Adder for the next term, reduced modulo 2^TERM_W
    always_comb begin
        sum_d = cur_q + m1_q;
    end

    // Next values of the three terms: reload, shift forward, or keep
    always_comb begin
        if (load_init) begin
            cur_d = INIT_CUR;
            m1_d  = INIT_M1;
            m2_d  = INIT_M2;
        end else if (advance) begin
            cur_d = sum_d;
            m1_d  = cur_q;
            m2_d  = m1_q;
        end else begin
            cur_d = cur_q;
            m1_d  = m1_q;
            m2_d  = m2_q;
        end
    end

    // Term registers
    always_ff @(posedge clk) begin
        cur_q <= cur_d;
        m1_q  <= m1_d;
        m2_q  <= m2_d;
    end

endmodule

// File: rtl/fib_out_sel.sv
// Output stage: shows the term that matches the controller state, at the
// output width. Restart shows 0, first-term shows 1, and generate or hold
// shows the current register.
// Assumes: OUT_W >= 1. Upper bits are zero-filled when OUT_W > TERM_W and the
// term is cut when OUT_W is narrower.
module fib_out_sel
    import fib_pkg::*;
#(
    parameter int TERM_W = 16,
    parameter int OUT_W  = 17
) (
    input  fib_state_e        state_q,
    input  logic [TERM_W-1:0] cur_q,
    output logic [OUT_W-1:0]  fib_out
);

    logic [OUT_W-1:0] cur_ext;

    // Width adaptation of the current term
    generate
        if (OUT_W > TERM_W) begin : g_pad
            localparam int PAD_W = OUT_W - TERM_W;
            assign cur_ext = {{PAD_W{1'b0}}, cur_q};
        end else begin : g_cut
            assign cur_ext = cur_q[OUT_W-1:0];
        end
    endgenerate

    // State-based selection of the visible term
    always_comb begin
        unique case (state_q)
            ST_RESTART: fib_out = '0;
            ST_FIRST:   fib_out = OUT_W'(1);
            default:    fib_out = cur_ext;
        endcase
    end

endmodule

// File: rtl/fibgen_top.sv
// Enable-gated Fibonacci generator top: wires the controller, the term
// datapath and the output stage together.
// Assumes: a single clock, with rst_n synchronous and active low.
module fibgen_top
    import fib_pkg::*;
#(
    parameter int TERM_W = 16,
    parameter int OUT_W  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [OUT_W-1:0] fib_out
);

    fib_state_e        state_q;
    logic              load_init;
    logic              advance;
    logic [TERM_W-1:0] cur_q;
    logic [TERM_W-1:0] m1_q;
    logic [TERM_W-1:0] m2_q;

    fib_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .state_q   (state_q),
        .load_init (load_init),
        .advance   (advance)
    );

    fib_term_path #(.TERM_W(TERM_W)) u_terms (
        .clk       (clk),
        .load_init (load_init),
        .advance   (advance),
        .cur_q     (cur_q),
        .m1_q      (m1_q),
        .m2_q      (m2_q)
    );

    fib_out_sel #(.TERM_W(TERM_W), .OUT_W(OUT_W)) u_out (
        .state_q   (state_q),
        .cur_q     (cur_q),
        .fib_out   (fib_out)
    );

endmodule

// File: rtl/fibgen_checker.sv
// Property checker for the Fibonacci generator, attached to the top by bind.
// Assumes: the bench holds rst_n low from time zero for at least one edge.
module fibgen_checker #(
    parameter int TERM_W = 16,
    parameter int OUT_W  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [OUT_W-1:0]  fib_out,
    input logic [1:0]        state_q,
    input logic [TERM_W-1:0] cur_q,
    input logic [TERM_W-1:0] m1_q,
    input logic [TERM_W-1:0] m2_q
);

    // Restart at an edge clears the output, whatever en is (R1, R2)
    assert_reset_clears_R2: assert property (@(posedge clk)
        !rst_n |=> (fib_out == '0));

    // First enabled edge after a restart shows one
    assert_first_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && en) |=> (fib_out == OUT_W'(1)));

    // The three term registers stay consistent with the recurrence
    assert_recurrence_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q == TERM_W'(m1_q + m2_q));

    // Enable low keeps the output steady
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(fib_out));

    // Leaving the hold state continues with the next term
    assert_resume_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'b11 && en) |=>
            (fib_out[TERM_W-1:0] == TERM_W'($past(cur_q) + $past(m1_q))));

    // Upper output bits stay zero
    generate
        if (OUT_W > TERM_W) begin : g_msb
            assert_msb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
                fib_out[OUT_W-1:TERM_W] == '0);
        end
    endgenerate

endmodule

bind fibgen_top fibgen_checker #(.TERM_W(TERM_W), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .fib_out (fib_out),
    .state_q (state_q),
    .cur_q   (cur_q),
    .m1_q    (m1_q),
    .m2_q    (m2_q)
);

// File: tb/fibgen_top_test.sv
`timescale 1ns/100ps
module fibgen_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [16:0] fib_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_cur = 16'd0;
    logic [15:0] m_prev = 16'd1;

    fibgen_top uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .fib_out (fib_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One edge: drive at the falling edge, step the model, compare after the rising edge
    task automatic cyc(input logic e, input logic r, input string tag);
        logic [15:0] nxt;
        en = e;
        rst_n = r;
        @(posedge clk);
        if (!r) begin
            m_cur = 16'd0;
            m_prev = 16'd1;
        end else if (e) begin
            nxt = m_cur + m_prev;
            m_prev = m_cur;
            m_cur = nxt;
        end
        #1;
        check(tag, fib_out, {1'b0, m_cur});
        check("R7", {16'd0, fib_out[16]}, 17'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: restart from time zero
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R1");
        // R9: enable low after restart stays at zero
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R9");
        // R3: opening terms 1 1 2 3 5 8
        cyc(1'b1, 1'b1, "R3");
        check("R3", fib_out, 17'd1);
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, "R3");
        check("R3", fib_out, 17'd8);
        // R5: long hold
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, "R5");
        check("R5", fib_out, 17'd8);
        // R6: resume with the next term
        cyc(1'b1, 1'b1, "R6");
        check("R6", fib_out, 17'd13);
        // R1: rst_n low between edges leaves the output alone until the edge
        en = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R1", fib_out, 17'd13);
        // R2: restart beats enable
        cyc(1'b1, 1'b0, "R2");
        check("R2", fib_out, 17'd0);
        cyc(1'b1, 1'b0, "R2");
        // R8: run past the 16-bit wrap
        for (int i = 1; i <= 30; i++) begin
            cyc(1'b1, 1'b1, "R8");
            if (i == 24) check("R8", fib_out, 17'd46368);
            if (i == 25) check("R8", fib_out, 17'd9489);
        end
        // R4/R5/R6: every 8-edge enable pattern from a fresh restart
        for (int p = 0; p < 256; p++) begin
            cyc(1'b0, 1'b0, "R1");
            for (int b = 0; b < 8; b++) begin
                cyc(p[b], 1'b1, p[b] ? "R4" : "R5");
            end
        end
        // R6: hold straight from the first term, then resume
        cyc(1'b1, 1'b0, "R2");
        cyc(1'b1, 1'b1, "R3");
        cyc(1'b0, 1'b1, "R5");
        cyc(1'b1, 1'b1, "R6");
        check("R6", fib_out, 17'd1);
        cyc(1'b1, 1'b1, "R6");
        check("R6", fib_out, 17'd2);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule